// File: doc/BRIEF.md
# Gapless Double-Buffered Serial Master

This block is a synchronous serial master of the SPI kind. Software places a data word in a single-entry holding buffer. When the shift engine is free, it moves that word into its shift register. It then clocks the word out on the serial data output, most significant bit first, and assembles the word arriving on the serial data input at the same time. A dedicated baud generator paces the serial clock. It is a down-counter that reloads from a 16-bit value, followed by a divide-by-two that the two clock-phase states of the controller provide.

The holding buffer lets software queue the next word while the current frame is on the wire. If the buffer is full when the last bit of a frame ends, the next word enters the shift register on that same edge. The wire then shows no pause, so chained frames of width N look exactly like one frame of width 2N.

The frame width is set between 2 and 16 bits. The width and the baud value are only changed while the block is disabled. The controller has four states:
- `ST_OFF`: disabled.
- `ST_IDLE`: enabled, serial clock parked low, waiting for a word.
- `ST_LEAD`: serial clock low, counting toward the rising edge.
- `ST_TRAIL`: serial clock high, counting toward the falling edge.

The transitions are:
- any state goes to `ST_OFF` when enable is low.
- `ST_OFF` goes to `ST_IDLE` when enable is high.
- `ST_IDLE` goes to `ST_LEAD` when the buffer is full, and the word is taken.
- `ST_LEAD` goes to `ST_TRAIL` on a baud tick, which is the rising edge where the input is sampled.
- `ST_TRAIL` goes to `ST_LEAD` on a baud tick that is not the last bit, which is the falling edge where the next bit is shifted out.
- `ST_TRAIL` goes to `ST_LEAD` on the tick of the last bit when the buffer is full. This is the chained take.
- `ST_TRAIL` goes to `ST_IDLE` on the tick of the last bit when the buffer is empty.

Top module: `gapless_spi_master`

## Requirements
- R1: While reset is held, and right after it with enable low, `sck`=0, `sdo`=0, `tx_empty`=1, `rx_strobe`=0 and `tx_overrun`=0.
- R2: During a frame, `sck` toggles once every `baud_reload`+1 module clock cycles. Successive rising edges are therefore exactly 2×(`baud_reload`+1) cycles apart, and a reload of 0 gives half the module clock.
- R3: A frame has W bits. W is `frame_len_m1`+1 for a field value of 1 to 15, and W is 2 for a field value of 0. `sck` idles low, and `sdo` carries bits W-1 down to 0 of the word, each bit valid at its rising `sck` edge. Word bits above W-1 are never sent.
- R4: `sdi` is sampled on each rising `sck` edge. When the frame ends, `rx_word` holds the W received bits right-justified, first bit highest, with zeros above bit W-1. `rx_strobe` is high for exactly one cycle.
- R5: `tx_empty` goes low in the cycle after a write, and it returns high once the word has been moved into the shift register. In the idle state, the word is moved one cycle after it is written.
- R6: When the buffer is full at the falling edge that ends a frame, the next frame starts on that edge. The rising edges of the two frames stay evenly spaced, and 2W bits appear on `sdo` without interruption.
- R7: When the buffer is empty at the end of a frame, `sck` stays low and no further edges appear until a new word is written.
- R8: A write while the buffer is full and not being taken replaces the stored word and sets `tx_overrun`. The replaced word is never sent. `tx_overrun` stays set until enable goes low or reset.
- R9: A write in the same cycle that the buffer is handed to the shift register stores the new word as the next one. In that case `tx_overrun` is not set, and both words go out back to back.
- R10: With `en` low, `sck` and `sdo` go low on the next cycle and the running frame is dropped without `rx_strobe`. The buffer empties, `tx_overrun` clears, and writes are ignored, so no frame follows when enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable; low stops and clears the engine |
| frame_len_m1 | input | 4 | Frame width minus one (0 acts as a 2-bit frame) |
| baud_reload | input | 16 | Reload value of the baud down-counter |
| tx_wr | input | 1 | Write strobe for the holding buffer |
| tx_word | input | 16 | Word to place in the holding buffer |
| sdi | input | 1 | Serial data input |
| sck | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data output |
| tx_empty | output | 1 | Holding buffer can take a word |
| tx_overrun | output | 1 | Sticky: a queued word was overwritten |
| rx_word | output | 16 | Last received word, right-justified |
| rx_strobe | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
The two functions that can meet in one cycle are a fresh buffer write and the hand-over of the buffered word to the shift register. The bench provokes this by raising the write strobe on two consecutive cycles while the block is idle: the second write lands exactly on the cycle in which the first word is taken. The result is judged correct when the overrun flag stays clear and both words appear on the data line as one unbroken 2W-bit stream with even clock spacing. A second check is the opposite case: a third write, arriving while a word is still queued, must replace the queued word and set the flag.

// File: rtl/gsm_pkg.sv
package gsm_pkg;

    // Controller states of the serial master
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,  // block disabled
        ST_IDLE  = 2'd1,  // enabled, waiting for a queued word
        ST_LEAD  = 2'd2,  // serial clock low half
        ST_TRAIL = 2'd3   // serial clock high half
    } gsm_state_e;

endpackage

// File: rtl/gsm_baud_gen.sv
module gsm_baud_gen #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] reload,
    output logic              tick
);

    logic [BAUD_W-1:0] cnt_q;

    // A tick marks the end of one half period of the serial clock
    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // With a non-zero reload two ticks never follow each other
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (reload != '0)) |=> !tick);  // R2

endmodule

// File: rtl/gsm_hold_buf.sv
module gsm_hold_buf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] word,
    output logic              overrun
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full    <= 1'b0;
            word    <= '0;
            overrun <= 1'b0;
        end else if (!en) begin
            full    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (wr) begin
                word <= wr_word;
                full <= 1'b1;
                if (full && !take) begin
                    overrun <= 1'b1;
                end
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    AST_TAKE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);  // R5

    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && take && !wr) |=> !full);  // R5

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr) |=> full);  // R9

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && overrun) |=> overrun);  // R8

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!full && !overrun));  // R10

endmodule

// File: rtl/gsm_frame_fsm.sv
module gsm_frame_fsm
    import gsm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_word,
    input  logic              sdi,
    output logic              run,
    output logic              take,
    output logic              sck,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_strobe
);

    localparam logic [LEN_W:0] W_ONE = (LEN_W+1)'(1);
    localparam logic [LEN_W:0] W_TWO = (LEN_W+1)'(2);

    gsm_state_e        state_q, state_d;
    logic [LEN_W:0]    wdt;
    logic [LEN_W-1:0]  bit_cnt;
    logic              last_bit;
    logic              frame_end;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] tx_nxt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_mask;

    // Effective frame width, at least two bits
    assign wdt       = (len_m1 == '0) ? W_TWO : ({1'b0, len_m1} + W_ONE);
    assign last_bit  = ({1'b0, bit_cnt} == (wdt - W_ONE));
    assign frame_end = (state_q == ST_TRAIL) && tick && last_bit;
    assign run       = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
    assign take      = en && buf_full && ((state_q == ST_IDLE) || frame_end);
    assign tx_nxt    = tx_sh << 1;

    // Receive mask: one bit per data position below the frame width
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        localparam logic [LEN_W:0] BIT_IDX = (LEN_W+1)'(gi);
        assign rx_mask[gi] = (BIT_IDX < wdt);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (buf_full) begin
                        state_d = ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        state_d = ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (!last_bit || buf_full) begin
                            state_d = ST_LEAD;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: begin
                    state_d = ST_OFF;
                end
            endcase
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck       <= 1'b0;
            sdo       <= 1'b0;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            rx_word   <= '0;
            rx_strobe <= 1'b0;
        end else if (!en) begin
            sck       <= 1'b0;
            sdo       <= 1'b0;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (take) begin
                tx_sh   <= buf_word;
                sdo     <= buf_word[wdt-W_ONE];
                bit_cnt <= '0;
            end
            if ((state_q == ST_LEAD) && tick) begin
                sck   <= 1'b1;
                rx_sh <= {rx_sh[DATA_W-2:0], sdi};
            end
            if ((state_q == ST_TRAIL) && tick) begin
                sck <= 1'b0;
                if (!last_bit) begin
                    tx_sh   <= tx_nxt;
                    sdo     <= tx_nxt[wdt-W_ONE];
                    bit_cnt <= bit_cnt + 1'b1;
                end else begin
                    rx_word   <= rx_sh & rx_mask;
                    rx_strobe <= 1'b1;
                    if (!buf_full) begin
                        sdo <= 1'b0;
                    end
                end
            end
        end
    end

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) || (state_q == ST_OFF)) |-> !sck);  // R7

    AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(sck));  // R2

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);  // R4

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sck && !sdo && !rx_strobe));  // R10

endmodule

// File: rtl/gapless_spi_master.sv
module gapless_spi_master #(
    parameter int DATA_W = 16,
    parameter int BAUD_W = 16,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LEN_W-1:0]  frame_len_m1,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              sdi,
    output logic              sck,
    output logic              sdo,
    output logic              tx_empty,
    output logic              tx_overrun,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_strobe
);

    logic              run;
    logic              tick;
    logic              take;
    logic              buf_full;
    logic [DATA_W-1:0] buf_word;

    gsm_baud_gen #(
        .BAUD_W (BAUD_W)
    ) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (baud_reload),
        .tick   (tick)
    );

    gsm_hold_buf #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr      (tx_wr),
        .wr_word (tx_word),
        .take    (take),
        .full    (buf_full),
        .word    (buf_word),
        .overrun (tx_overrun)
    );

    gsm_frame_fsm #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .len_m1    (frame_len_m1),
        .tick      (tick),
        .buf_full  (buf_full),
        .buf_word  (buf_word),
        .sdi       (sdi),
        .run       (run),
        .take      (take),
        .sck       (sck),
        .sdo       (sdo),
        .rx_word   (rx_word),
        .rx_strobe (rx_strobe)
    );

    assign tx_empty = !buf_full;

endmodule

// File: tb/sim_gapless_spi_master.sv
module sim_gapless_spi_master;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [3:0]  len;   // frame_len_m1
        logic [15:0] rld;   // baud reload
        logic [15:0] dat;   // word written
        logic        inv;   // sdi = sdo ^ inv
        logic [4:0]  ew;    // expected width
        logic [15:0] etx;   // expected bits on sdo
        logic [15:0] erx;   // expected rx_word
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd7,  16'd0, 16'h00A5, 1'b0, 5'd8,  16'h00A5, 16'h00A5},
        '{4'd15, 16'd1, 16'h1234, 1'b0, 5'd16, 16'h1234, 16'h1234},
        '{4'd3,  16'd2, 16'h0009, 1'b1, 5'd4,  16'h0009, 16'h0006},
        '{4'd0,  16'd0, 16'h0002, 1'b0, 5'd2,  16'h0002, 16'h0002},
        '{4'd1,  16'd3, 16'h0001, 1'b1, 5'd2,  16'h0001, 16'h0002},
        '{4'd11, 16'd0, 16'h0ABC, 1'b0, 5'd12, 16'h0ABC, 16'h0ABC},
        '{4'd15, 16'd4, 16'h8001, 1'b1, 5'd16, 16'h8001, 16'h7FFE},
        '{4'd4,  16'd0, 16'hFFE5, 1'b0, 5'd5,  16'h0005, 16'h0005}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  frame_len_m1 = '0;
    logic [15:0] baud_reload = '0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_word = '0;
    logic        inv_q = 1'b0;
    logic        sdi;
    logic        sck, sdo, tx_empty, tx_overrun, rx_strobe;
    logic [15:0] rx_word;

    int n_chk = 0;
    int n_fail = 0;

    // Bench-side monitor state
    logic        mon_clr = 1'b0;
    logic        sck_prev = 1'b0;
    logic [63:0] bits = '0;
    logic [15:0] rx_log [4];
    int cyc = 0, rise_cnt = 0, rxv_cnt = 0, last_rise = 0;
    int iv_min = 0, iv_max = 0;
    bit have = 1'b0;

    assign sdi = sdo ^ inv_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    gapless_spi_master u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .frame_len_m1 (frame_len_m1),
        .baud_reload  (baud_reload),
        .tx_wr        (tx_wr),
        .tx_word      (tx_word),
        .sdi          (sdi),
        .sck          (sck),
        .sdo          (sdo),
        .tx_empty     (tx_empty),
        .tx_overrun   (tx_overrun),
        .rx_word      (rx_word),
        .rx_strobe    (rx_strobe)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            rise_cnt = 0; rxv_cnt = 0; bits = '0; have = 1'b0;
            iv_min = 1000000; iv_max = 0;
        end else begin
            if (sck && !sck_prev) begin
                rise_cnt = rise_cnt + 1;
                bits = {bits[62:0], sdo};
                if (have) begin
                    if (cyc - last_rise < iv_min) iv_min = cyc - last_rise;
                    if (cyc - last_rise > iv_max) iv_max = cyc - last_rise;
                end
                have = 1'b1;
                last_rise = cyc;
            end
            if (rx_strobe) begin
                if (rxv_cnt < 4) rx_log[rxv_cnt] = rx_word;
                rxv_cnt = rxv_cnt + 1;
            end
        end
        sck_prev = sck;
    end

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        step();
        mon_clr = 1'b0;
    endtask

    task automatic wait_rx(input int n, input int lim);
        for (int k = 0; k < lim && rxv_cnt < n; k++) step();
    endtask

    task automatic configure(input logic [3:0] len, input logic [15:0] rld, input logic inv);
        en = 1'b0; tx_wr = 1'b0;
        step();
        frame_len_m1 = len; baud_reload = rld; inv_q = inv;
        en = 1'b1;
        step(2);
        clear_mon();
    endtask

    task automatic write_word(input logic [15:0] w);
        tx_word = w; tx_wr = 1'b1;
        step();
        tx_wr = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        step(3);
        check("R1 sck",      64'(sck),        64'd0);
        check("R1 sdo",      64'(sdo),        64'd0);
        check("R1 tx_empty", 64'(tx_empty),   64'd1);
        check("R1 rx_strobe",64'(rx_strobe),  64'd0);
        check("R1 overrun",  64'(tx_overrun), 64'd0);
        rst_n = 1'b1;
        step(2);
        check("R1 sck after release", 64'(sck), 64'd0);

        // Table-driven frames: R2 R3 R4 R7
        for (int i = 0; i < NVEC; i++) begin
            configure(VECS[i].len, VECS[i].rld, VECS[i].inv);
            write_word(VECS[i].dat);
            wait_rx(1, 2000);
            step(4 * (int'(VECS[i].rld) + 1) + 4);
            check("R3 bit count", 64'(rise_cnt), 64'(VECS[i].ew));
            check("R3 sdo bits",  bits, 64'(VECS[i].etx));
            check("R2 min spacing", 64'(iv_min), 64'(2 * (int'(VECS[i].rld) + 1)));
            check("R2 max spacing", 64'(iv_max), 64'(2 * (int'(VECS[i].rld) + 1)));
            check("R4 rx_word",  64'(rx_log[0]), 64'(VECS[i].erx));
            check("R7 one frame only", 64'(rxv_cnt), 64'd1);
            check("R7 sck parked", 64'(sck), 64'd0);
        end

        // R5: empty flag timing from idle
        configure(4'd7, 16'd2, 1'b0);
        tx_word = 16'h003C; tx_wr = 1'b1;
        step();
        tx_wr = 1'b0;
        check("R5 empty low after write", 64'(tx_empty), 64'd0);
        step();
        check("R5 empty high after take", 64'(tx_empty), 64'd1);
        wait_rx(1, 2000);
        step(10);

        // R6: chained frames with a write during the first frame
        configure(4'd7, 16'd1, 1'b0);
        write_word(16'h00C3);
        step(6);
        write_word(16'h005A);
        wait_rx(2, 2000);
        step(12);
        check("R6 bit count", 64'(rise_cnt), 64'd16);
        check("R6 stream", bits, 64'h0000_0000_0000_C35A);
        check("R6 min spacing", 64'(iv_min), 64'd4);
        check("R6 max spacing", 64'(iv_max), 64'd4);
        check("R6 first rx", 64'(rx_log[0]), 64'h00C3);
        check("R6 second rx", 64'(rx_log[1]), 64'h005A);

        // R9: write on the very cycle the buffer is taken
        configure(4'd3, 16'd0, 1'b0);
        tx_word = 16'h000A; tx_wr = 1'b1;
        step();
        tx_word = 16'h0005;
        step();
        tx_wr = 1'b0;
        wait_rx(2, 2000);
        step(6);
        check("R9 no overrun", 64'(tx_overrun), 64'd0);
        check("R9 stream", bits, 64'h0000_0000_0000_00A5);
        check("R9 spacing", 64'(iv_max), 64'd2);
        check("R9 frames", 64'(rxv_cnt), 64'd2);

        // R8: overwrite while a word is already queued
        configure(4'd7, 16'd2, 1'b0);
        write_word(16'h0011);
        step(2);
        write_word(16'h0022);
        write_word(16'h0033);
        check("R8 overrun set", 64'(tx_overrun), 64'd1);
        wait_rx(2, 2000);
        step(20);
        check("R8 frames", 64'(rxv_cnt), 64'd2);
        check("R8 first word", 64'(rx_log[0]), 64'h0011);
        check("R8 replaced word", 64'(rx_log[1]), 64'h0033);
        check("R8 sticky", 64'(tx_overrun), 64'd1);

        // R10: disable mid-frame, writes ignored while off
        configure(4'd15, 16'd3, 1'b0);
        write_word(16'hFFFF);
        write_word(16'hFFFF);
        step(20);
        en = 1'b0;
        step();
        check("R10 sck low", 64'(sck), 64'd0);
        check("R10 sdo low", 64'(sdo), 64'd0);
        check("R10 buffer emptied", 64'(tx_empty), 64'd1);
        check("R10 overrun cleared", 64'(tx_overrun), 64'd0);
        clear_mon();
        write_word(16'h1234);
        step(30);
        en = 1'b1;
        step(60);
        check("R10 no edges", 64'(rise_cnt), 64'd0);
        check("R10 no strobe", 64'(rxv_cnt), 64'd0);
        check("R10 still empty", 64'(tx_empty), 64'd1);

        summary();
        $finish;
    end

endmodule